// File: doc/BRIEF.md
# External Interrupt Edge Detector

This peripheral watches a single external interrupt pin and raises a sticky request flag when a qualifying transition arrives. The pin first passes through a synchroniser. A 4-bit configuration word then decides whether the pin is used at all, which level counts as active, and whether one edge direction or both directions raise the request. The host reads and writes the configuration word through a plain write-strobe interface, and it drops the request with a one-cycle clear strobe.

Gating and polarity inversion come before the edge detector. Because of this, rewriting the enable or polarity bit while the pin holds still can change the conditioned signal and raise a spurious request. Software clears that request with the same strobe. The block also gives a level-test output for polling the pin at its active level. It drives a timer-gate enable straight from the configuration word, for use by a nearby timer.

Top module: `extint_edge_unit`

## Requirements
- R1: After a synchronous active-low reset, the configuration word reads 0000 and `irq_flag`, `level_hit` and `tmr_gate_en` are all 0.
- R2: Field layout of the configuration word: bit 3 = pin enable, bit 2 = polarity (0 = falling edge and low level active, 1 = rising edge and high level active), bit 1 = edge mode (0 = single edge, 1 = both edges), bit 0 = timer-gate enable. A write with `cfg_wr_en` high stores all four bits, and `cfg_rdata` returns them from the next cycle on.
- R3: `tmr_gate_en` equals configuration bit 0.
- R4: While bit 3 is 0, pin transitions set no request and `level_hit` stays 0.
- R5: In single-edge mode with the pin enabled, a falling pin edge (polarity 0) or a rising pin edge (polarity 1) sets `irq_flag` on the third rising clock edge after the pin changes. The opposite edge sets nothing.
- R6: In both-edge mode with the pin enabled, every pin transition sets `irq_flag` with the same latency as R5.
- R7: `level_hit` is 1 exactly when the pin is enabled and the synchronised pin equals the active level chosen by bit 2. It follows a pin change after two clock edges.
- R8: Once set, `irq_flag` stays high until `flag_clr` is sampled high, and it is low after that edge.
- R9: If a qualifying edge and `flag_clr` land on the same clock edge, `irq_flag` ends up set.
- R10: With the pin static, a write that changes bit 2 or bit 3 so that the conditioned pin becomes active sets `irq_flag` on the clock edge after the write. `flag_clr` then removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 4 | Configuration value to store |
| cfg_rdata | output | 4 | Current configuration word |
| flag_clr | input | 1 | One-cycle request clear strobe |
| irq_flag | output | 1 | Sticky interrupt request |
| level_hit | output | 1 | Pin enabled and at its active level |
| tmr_gate_en | output | 1 | Timer-gate enable from configuration bit 0 |

## Verification
The bench uses the default two-stage synchroniser, so the pin-to-flag latency it expects is fixed at three edges and can be checked cycle by cycle. The configuration word is only four bits wide. The bench therefore sweeps all sixteen settings against both starting pin levels and both transition directions, with each expected flag and level value computed from the field meanings. Directed sequences then cover the spurious request caused by polarity and enable rewrites, and a clear that collides with a set.

// File: rtl/extint_pkg.sv
// Shared types for the external interrupt edge detector.
// Assumes the host software decodes the field order of cfg_t.
package extint_pkg;
    localparam int CFG_W = 4;

    typedef struct packed {
        logic pin_en;      // bit 3: pin used at all
        logic pol_high;    // bit 2: 1 = rising / high active
        logic both_edges;  // bit 1: 1 = either direction
        logic tmr_en;      // bit 0: timer-gate enable
    } cfg_t;
endpackage

// File: rtl/extint_sync.sv
// Multi-flop synchroniser for the asynchronous pin.
// Assumes STAGES >= 2. Output lags the input by STAGES clock edges.
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/extint_cfg_reg.sv
// Configuration word holder with a full-width write and a direct readback.
// Assumes writes are single-cycle strobes from the host.
module extint_cfg_reg
    import extint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);
    // Store the whole word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= cfg_t'(wdata);
    end

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == $past(wdata)));
    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/extint_edge_det.sv
// Gates and inverts the synchronised pin, then finds qualifying edges.
// Assumes the conditioned signal is 1 when the pin sits at its active level.
module extint_edge_det
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  cfg_t cfg,
    output logic cond_lvl,
    output logic edge_hit
);
    logic cond_prev;

    assign cond_lvl = cfg.pin_en & ~(pin_s ^ cfg.pol_high);

    // Remember the previous conditioned sample.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_prev <= 1'b0;
        else        cond_prev <= cond_lvl;
    end

    // Pick rising-only or any-change detection.
    always_comb begin
        if (cfg.both_edges) edge_hit = cond_lvl ^ cond_prev;
        else                edge_hit = cond_lvl & ~cond_prev;
    end

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.pin_en && !$past(cfg.pin_en)) |-> !edge_hit);
endmodule

// File: rtl/extint_flag.sv
// Sticky request flag: set by a qualifying edge, cleared by the host strobe.
// Assumes a set and a clear in one cycle must leave the flag set.
module extint_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/extint_edge_unit.sv
// Top of the external interrupt edge detector: synchroniser, configuration
// word, conditioned edge detection and sticky request flag.
// Assumes pin_in is asynchronous and host strobes are one cycle wide.
module extint_edge_unit
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             flag_clr,
    output logic             irq_flag,
    output logic             level_hit,
    output logic             tmr_gate_en
);
    logic pin_s;
    logic hit;
    cfg_t cfg;

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_s)
    );

    extint_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata), .cfg_q(cfg)
    );

    extint_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .cfg(cfg),
        .cond_lvl(level_hit), .edge_hit(hit)
    );

    extint_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(hit), .clr_i(flag_clr), .flag_q(irq_flag)
    );

    assign cfg_rdata   = cfg;
    assign tmr_gate_en = cfg.tmr_en;

    // R7
    level_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_hit |-> cfg_rdata[3]);
    // R3
    tmr_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (tmr_gate_en == $past(cfg_wdata[0])));
endmodule

// File: tb/extint_edge_unit_tb.sv
module extint_edge_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic [3:0] cfg_rdata;
    logic       flag_clr = 1'b0;
    logic       irq_flag, level_hit, tmr_gate_en;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    extint_edge_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .flag_clr(flag_clr), .irq_flag(irq_flag), .level_hit(level_hit),
        .tmr_gate_en(tmr_gate_en)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] v);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        check("R1 cfg", cfg_rdata, 4'h0);
        check("R1 flag", {3'b0, irq_flag}, 4'h0);
        check("R1 level", {3'b0, level_hit}, 4'h0);
        check("R1 tmr", {3'b0, tmr_gate_en}, 4'h0);

        // Sweep every configuration against both start levels.
        for (int c = 0; c < 16; c++) begin
            for (int p0 = 0; p0 < 2; p0++) begin
                logic en, pol, both, p1, exp_f;
                en = c[3]; pol = c[2]; both = c[1];
                p1 = ~p0[0];
                @(negedge clk); pin_in = p0[0];
                wait_n(4);
                wr(c[3:0]);
                wait_n(3);
                clr_pulse();
                check("R8 clear", {3'b0, irq_flag}, 4'h0);
                check("R2 readback", cfg_rdata, c[3:0]);
                check("R3 tmr gate", {3'b0, tmr_gate_en}, {3'b0, c[0]});
                check("R7 level start", {3'b0, level_hit}, {3'b0, en & (p0[0] == pol)});
                @(negedge clk); pin_in = p1;
                wait_n(2);
                check("R5 latency", {3'b0, irq_flag}, 4'h0);
                check("R7 level after", {3'b0, level_hit}, {3'b0, en & (p1 == pol)});
                wait_n(1);
                exp_f = en & (both | (p1 == pol));
                if (!en)      check("R4 disabled", {3'b0, irq_flag}, 4'h0);
                else if (both) check("R6 both edges", {3'b0, irq_flag}, {3'b0, exp_f});
                else          check("R5 single edge", {3'b0, irq_flag}, {3'b0, exp_f});
                if (exp_f) begin
                    wait_n(5);
                    check("R8 sticky", {3'b0, irq_flag}, 4'h1);
                end
            end
        end

        // R4: many toggles while disabled, both-edge mode selected.
        wr(4'b0110);
        wait_n(3);
        clr_pulse();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); pin_in = ~pin_in;
            wait_n(3);
            check("R4 toggles ignored", {3'b0, irq_flag}, 4'h0);
            check("R4 level low", {3'b0, level_hit}, 4'h0);
        end

        // R9: clear lands on the same edge as the set.
        @(negedge clk); pin_in = 1'b0;
        wr(4'b1110);
        wait_n(4);
        clr_pulse();
        check("R9 pre", {3'b0, irq_flag}, 4'h0);
        @(negedge clk); pin_in = 1'b1;
        wait_n(2);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R9 set wins", {3'b0, irq_flag}, 4'h1);
        clr_pulse();
        check("R8 clear after R9", {3'b0, irq_flag}, 4'h0);

        // R10: polarity flip with the pin held high.
        wr(4'b1000);
        wait_n(3);
        clr_pulse();
        check("R10 pre pol", {3'b0, irq_flag}, 4'h0);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = 4'b1100;
        @(negedge clk); cfg_wr_en = 1'b0;
        check("R10 not yet", {3'b0, irq_flag}, 4'h0);
        wait_n(1);
        check("R10 polarity spurious", {3'b0, irq_flag}, 4'h1);
        clr_pulse();
        check("R10 polarity cleared", {3'b0, irq_flag}, 4'h0);

        // R10: enabling with the pin held at the low active level.
        @(negedge clk); pin_in = 1'b0;
        wr(4'b0000);
        wait_n(4);
        clr_pulse();
        check("R10 pre en", {3'b0, irq_flag}, 4'h0);
        wr(4'b1000);
        wait_n(1);
        check("R10 enable spurious", {3'b0, irq_flag}, 4'h1);
        clr_pulse();
        check("R10 enable cleared", {3'b0, irq_flag}, 4'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule